// File: doc/BRIEF.md
# Bus Idle Gap Timer

This block watches the two receive lines of a shared serial backplane bus and measures how long the bus has been quiet, in arbitration clock cycles. The bus is quiet only while both the data line and the strobe line are low. The quiet time is sorted into three nested gap classes: acknowledge, subaction and arbitration reset. Each class has two thresholds. At the first, a detection flag rises. At the second, which comes four cycles later, the node is allowed to drive the bus. The four extra cycles cover the worst-case offset between the arbitration sequencers of any two nodes.

A node that wants to send chooses the gap class it is waiting for and pulses a request. The block keeps that request. When the quiet time reaches the drive threshold of the chosen class, it issues a grant pulse one cycle long. Both bus inputs are asynchronous to the arbitration clock, so each goes through a two-flop synchronizer before the idle test. All thresholds are applied to the synchronized values. The default thresholds are:

| Class | Detection | Drive allowed |
|---|---|---|
| Acknowledge | 4 | 8 |
| Subaction | 16 | 20 |
| Arbitration reset | 28 | 32 |

At about 20.35 ns per arbitration clock, 4 cycles is roughly 81 ns.

Top module: `idle_gap_timer`

## Requirements
- R1: The bus counts as idle only when both synchronized lines are low. The idle count returns to zero after any synchronized cycle in which either line is high. Holding only one line high keeps every detection flag low.
- R2: `ack_gap_o` is high exactly while the idle count is at least 4.
- R3: `sub_gap_o` is high exactly while the idle count is at least 16. It is never high without `ack_gap_o`.
- R4: `arb_gap_o` is high exactly while the idle count is at least 28. It is never high without the other two flags.
- R5: The idle count stops at 32 and does not wrap. However long the bus stays idle, all three flags stay high.
- R6: `longest_gap_o` reports the longest class reached, with these codes: 0 for none, 1 for acknowledge, 2 for subaction, 3 for arbitration reset.
- R7: A request is accepted when it carries a class code of 1, 2 or 3 and no other request is pending. The grant `tx_grant_o` is high for exactly one cycle, in the first cycle in which the request is pending and the idle count has reached the drive threshold of the stored class (8, 20 or 32). That pulse clears the pending request. Bus activity does not cancel a pending request.
- R8: A request with class code 0 is ignored and never produces a grant. A request made while another request is pending is ignored, and the stored class is kept.
- R9: The idle count is 1 in the cycle after the third rising edge at which the raw lines are both low. The flag of a 4-cycle gap therefore appears after the sixth such edge and not after the fifth.
- R10: While reset is asserted and right after it, all outputs are low, and no request is pending.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Arbitration clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| bus_data_i | input | 1 | Raw received data line, asynchronous |
| bus_strobe_i | input | 1 | Raw received strobe line, asynchronous |
| wait_class_i | input | 2 | Gap class to wait for (0 none, 1 ack, 2 subaction, 3 arbitration reset) |
| tx_req_i | input | 1 | Request strobe, sampled on the clock edge |
| ack_gap_o | output | 1 | Acknowledge gap detected |
| sub_gap_o | output | 1 | Subaction gap detected |
| arb_gap_o | output | 1 | Arbitration reset gap detected |
| longest_gap_o | output | 2 | Longest class reached so far in the current gap |
| tx_grant_o | output | 1 | One-cycle grant to drive the bus |

## Verification
The assertions assume that the request and class inputs are synchronous to the arbitration clock and stable around its rising edge. They also assume that the raw bus lines reach the synchronizer without glitches shorter than a cycle. The bench changes every input only on the falling clock edge, so each line is held for whole cycles. Within that rule the bench mixes random lengths of busy and idle time, gaps of exact length at each threshold, and requests sent during busy time, during idle time and while another request is pending.

// File: rtl/gap_timer_pkg.sv
package gap_timer_pkg;

  // Gap class codes. The grant logic and longest_gap_o both use this order.
  typedef enum logic [1:0] {
    GAP_NONE = 2'd0,
    GAP_ACK  = 2'd1,
    GAP_SUB  = 2'd2,
    GAP_ARB  = 2'd3
  } gap_class_e;

  localparam int NUM_CLASSES = 3;

endpackage

// File: rtl/gap_sync.sv
// Two-flop synchronizer, one pair per input bit.
module gap_sync #(
  parameter int W = 2
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [W-1:0] d_i,
  output logic [W-1:0] q_o
);

  generate
    for (genvar i = 0; i < W; i++) begin : g_bit
      logic meta_q;
      logic stab_q;

      always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
          meta_q <= 1'b0;
          stab_q <= 1'b0;
        end else begin
          meta_q <= d_i[i];
          stab_q <= meta_q;
        end
      end

      assign q_o[i] = stab_q;
    end
  endgenerate

endmodule

// File: rtl/gap_idle_counter.sv
// Counts consecutive idle cycles. Clears on activity and stops at SAT.
module gap_idle_counter #(
  parameter int SAT = 32,
  parameter int CW  = $clog2(SAT + 1)
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          idle_i,
  output logic [CW-1:0] cnt_o
);

  localparam logic [CW-1:0] SAT_V = CW'(SAT);

  logic [CW-1:0] cnt_q;
  logic [CW-1:0] cnt_d;
  logic          cnt_en;

  always_comb begin
    cnt_en = 1'b0;
    cnt_d  = cnt_q;
    if (!idle_i) begin
      cnt_en = (cnt_q != '0);
      cnt_d  = '0;
    end else if (cnt_q != SAT_V) begin
      cnt_en = 1'b1;
      cnt_d  = cnt_q + 1'b1;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q <= '0;
    end else if (cnt_en) begin
      cnt_q <= cnt_d;
    end
  end

  assign cnt_o = cnt_q;

endmodule

// File: rtl/gap_classifier.sv
// Compares the idle count with the detection and drive thresholds of each class.
module gap_classifier
  import gap_timer_pkg::*;
#(
  parameter int CW      = 6,
  parameter int ACK_DET = 4,
  parameter int ACK_GO  = 8,
  parameter int SUB_DET = 16,
  parameter int SUB_GO  = 20,
  parameter int ARB_DET = 28,
  parameter int ARB_GO  = 32
) (
  input  logic [CW-1:0]          cnt_i,
  output logic [NUM_CLASSES-1:0] det_o,
  output logic [NUM_CLASSES-1:0] go_o,
  output logic [1:0]             longest_o
);

  localparam int DET_TH [NUM_CLASSES] = '{ACK_DET, SUB_DET, ARB_DET};
  localparam int GO_TH  [NUM_CLASSES] = '{ACK_GO, SUB_GO, ARB_GO};

  generate
    for (genvar i = 0; i < NUM_CLASSES; i++) begin : g_cls
      assign det_o[i] = (cnt_i >= CW'(DET_TH[i]));
      assign go_o[i]  = (cnt_i >= CW'(GO_TH[i]));
    end
  endgenerate

  always_comb begin
    if (det_o[2])      longest_o = GAP_ARB;
    else if (det_o[1]) longest_o = GAP_SUB;
    else if (det_o[0]) longest_o = GAP_ACK;
    else               longest_o = GAP_NONE;
  end

endmodule

// File: rtl/gap_grant.sv
// Holds one request and its class. Issues a one-cycle grant when that class may drive the bus.
module gap_grant
  import gap_timer_pkg::*;
(
  input  logic                   clk_i,
  input  logic                   rst_ni,
  input  logic                   req_i,
  input  logic [1:0]             cls_i,
  input  logic [NUM_CLASSES-1:0] go_i,
  output logic                   grant_o
);

  logic       pend_q, pend_d;
  logic [1:0] cls_q, cls_d;
  logic       cls_en;
  logic       go_sel;

  always_comb begin
    case (cls_q)
      GAP_ACK: go_sel = go_i[0];
      GAP_SUB: go_sel = go_i[1];
      GAP_ARB: go_sel = go_i[2];
      default: go_sel = 1'b0;
    endcase
  end

  assign grant_o = pend_q && go_sel;

  always_comb begin
    pend_d = pend_q;
    cls_d  = cls_q;
    cls_en = 1'b0;
    if (grant_o) begin
      pend_d = 1'b0;
    end else if (!pend_q && req_i && (cls_i != GAP_NONE)) begin
      pend_d = 1'b1;
      cls_d  = cls_i;
      cls_en = 1'b1;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      pend_q <= 1'b0;
    end else begin
      pend_q <= pend_d;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cls_q <= GAP_NONE;
    end else if (cls_en) begin
      cls_q <= cls_d;
    end
  end

endmodule

// File: rtl/idle_gap_timer.sv
module idle_gap_timer
  import gap_timer_pkg::*;
#(
  parameter int ACK_DET_CYC = 4,
  parameter int ACK_GO_CYC  = 8,
  parameter int SUB_DET_CYC = 16,
  parameter int SUB_GO_CYC  = 20,
  parameter int ARB_DET_CYC = 28,
  parameter int ARB_GO_CYC  = 32
) (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       bus_data_i,
  input  logic       bus_strobe_i,
  input  logic [1:0] wait_class_i,
  input  logic       tx_req_i,
  output logic       ack_gap_o,
  output logic       sub_gap_o,
  output logic       arb_gap_o,
  output logic [1:0] longest_gap_o,
  output logic       tx_grant_o
);

  localparam int SAT = ARB_GO_CYC;
  localparam int CW  = $clog2(SAT + 1);

  logic [1:0]             bus_sync;
  logic                   bus_idle;
  logic [CW-1:0]          idle_cnt;
  logic [NUM_CLASSES-1:0] det;
  logic [NUM_CLASSES-1:0] go;

  gap_sync #(.W(2)) u_sync (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .d_i    ({bus_data_i, bus_strobe_i}),
    .q_o    (bus_sync)
  );

  assign bus_idle = (bus_sync == 2'b00);

  gap_idle_counter #(.SAT(SAT), .CW(CW)) u_cnt (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .idle_i (bus_idle),
    .cnt_o  (idle_cnt)
  );

  gap_classifier #(
    .CW      (CW),
    .ACK_DET (ACK_DET_CYC),
    .ACK_GO  (ACK_GO_CYC),
    .SUB_DET (SUB_DET_CYC),
    .SUB_GO  (SUB_GO_CYC),
    .ARB_DET (ARB_DET_CYC),
    .ARB_GO  (ARB_GO_CYC)
  ) u_cls (
    .cnt_i     (idle_cnt),
    .det_o     (det),
    .go_o      (go),
    .longest_o (longest_gap_o)
  );

  gap_grant u_grant (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .req_i   (tx_req_i),
    .cls_i   (wait_class_i),
    .go_i    (go),
    .grant_o (tx_grant_o)
  );

  assign ack_gap_o = det[0];
  assign sub_gap_o = det[1];
  assign arb_gap_o = det[2];

endmodule

// File: rtl/gap_timer_checks.sv
module gap_timer_checks (
  input logic clk_i,
  input logic rst_ni,
  input logic bus_data_i,
  input logic bus_strobe_i,
  input logic idle_i,
  input logic ack_gap_o,
  input logic sub_gap_o,
  input logic arb_gap_o,
  input logic tx_grant_o
);

  logic [1:0] since_rst_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      since_rst_q <= 2'd0;
    end else if (since_rst_q != 2'd3) begin
      since_rst_q <= since_rst_q + 2'd1;
    end
  end

  // R1: activity on either raw line clears the detection three edges later.
  p_clear_r1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ((since_rst_q == 2'd3) && $past(bus_data_i || bus_strobe_i, 3)) |-> !ack_gap_o);

  // R3: the subaction flag implies the acknowledge flag.
  p_nest_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    sub_gap_o |-> ack_gap_o);

  // R4: the arbitration reset flag implies both shorter flags.
  p_nest_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    arb_gap_o |-> (sub_gap_o && ack_gap_o));

  // R5: the longest flag holds while the bus stays idle.
  p_hold_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (arb_gap_o && idle_i) |=> arb_gap_o);

  // R7: a grant lasts a single cycle.
  p_pulse_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    tx_grant_o |=> !tx_grant_o);

  // R7: no grant comes before the shortest gap has been detected.
  p_grant_after_ack_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    tx_grant_o |-> ack_gap_o);

endmodule

bind idle_gap_timer gap_timer_checks u_checks (
  .clk_i        (clk_i),
  .rst_ni       (rst_ni),
  .bus_data_i   (bus_data_i),
  .bus_strobe_i (bus_strobe_i),
  .idle_i       (bus_idle),
  .ack_gap_o    (ack_gap_o),
  .sub_gap_o    (sub_gap_o),
  .arb_gap_o    (arb_gap_o),
  .tx_grant_o   (tx_grant_o)
);

// File: tb/idle_gap_timer_tb_top.sv
module idle_gap_timer_tb_top;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       bus_data = 1'b1;
  logic       bus_strobe = 1'b1;
  logic [1:0] wait_class = 2'd0;
  logic       tx_req = 1'b0;
  logic       ack_gap, sub_gap, arb_gap, tx_grant;
  logic [1:0] longest_gap;

  int vectors = 0;
  int errors = 0;
  int grants_seen = 0;
  bit done = 1'b0;

  always #4 clk = ~clk;

  idle_gap_timer dut_i (
    .clk_i         (clk),
    .rst_ni        (rst_n),
    .bus_data_i    (bus_data),
    .bus_strobe_i  (bus_strobe),
    .wait_class_i  (wait_class),
    .tx_req_i      (tx_req),
    .ack_gap_o     (ack_gap),
    .sub_gap_o     (sub_gap),
    .arb_gap_o     (arb_gap),
    .longest_gap_o (longest_gap),
    .tx_grant_o    (tx_grant)
  );

  // Reference model, written from the requirements.
  bit [1:0] sync_q[$];
  int       m_idle;
  bit       m_pend;
  int       m_cls;
  bit       m_grant;
  bit       m_old_idle;

  function automatic int go_th(int c);
    if (c == 1) return 8;
    if (c == 2) return 20;
    if (c == 3) return 32;
    return 1000;
  endfunction

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sync_q.delete();
      sync_q.push_back(2'b00);
      sync_q.push_back(2'b00);
      m_idle = 0;
      m_pend = 0;
      m_cls  = 0;
    end else begin
      m_old_idle = (sync_q[0] == 2'b00);
      m_grant = m_pend && (m_idle >= go_th(m_cls));
      sync_q.push_back({bus_data, bus_strobe});
      void'(sync_q.pop_front());
      if (!m_old_idle) m_idle = 0;
      else if (m_idle < 32) m_idle = m_idle + 1;
      if (m_grant) m_pend = 0;
      else if (!m_pend && tx_req && wait_class != 2'd0) begin
        m_pend = 1;
        m_cls  = int'(wait_class);
      end
    end
  end

  task automatic chk(string req, int act, int exp);
    vectors++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d at %0t", req, act, exp, $time);
    end
  endtask

  // Compare with the model on every falling edge.
  always @(negedge clk) begin
    if (rst_n && !done) begin
      int lg;
      lg = (m_idle >= 28) ? 3 : (m_idle >= 16) ? 2 : (m_idle >= 4) ? 1 : 0;
      chk("R2 ack_gap", int'(ack_gap), int'(m_idle >= 4));
      chk("R3 sub_gap", int'(sub_gap), int'(m_idle >= 16));
      chk("R4 arb_gap", int'(arb_gap), int'(m_idle >= 28));
      chk("R6 longest_gap", int'(longest_gap), lg);
      chk("R7 tx_grant", int'(tx_grant), int'(m_pend && m_idle >= go_th(m_cls)));
      if (tx_grant) grants_seen++;
    end
  end

  task automatic cyc(bit d, bit s, bit r, logic [1:0] c);
    bus_data = d; bus_strobe = s; tx_req = r; wait_class = c;
    @(negedge clk);
  endtask

  task automatic busy(int n);
    for (int i = 0; i < n; i++) cyc(1, 1, 0, 2'd0);
  endtask

  task automatic quiet(int n);
    for (int i = 0; i < n; i++) cyc(0, 0, 0, 2'd0);
  endtask

  initial begin
    #(8 * 150000);
    if (!done) begin
      errors++;
      $display("FAIL watchdog actual=running expected=finished");
      done = 1'b1;
      $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    // R10: outputs low during reset.
    chk("R10 reset ack", int'(ack_gap), 0);
    chk("R10 reset longest", int'(longest_gap), 0);
    chk("R10 reset grant", int'(tx_grant), 0);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R10 after reset grant", int'(tx_grant), 0);
    busy(5);

    // R9: latency through the synchronizer.
    quiet(5);
    chk("R9 five edges ack", int'(ack_gap), 0);
    quiet(1);
    chk("R9 six edges ack", int'(ack_gap), 1);

    // R1: one line high is not idle.
    for (int i = 0; i < 40; i++) cyc(0, 1, 0, 2'd0);
    chk("R1 strobe only ack", int'(ack_gap), 0);
    for (int i = 0; i < 40; i++) cyc(1, 0, 0, 2'd0);
    chk("R1 data only ack", int'(ack_gap), 0);

    // R5: a long idle keeps the flags high.
    quiet(120);
    chk("R5 long idle arb", int'(arb_gap), 1);
    chk("R5 long idle longest", int'(longest_gap), 3);

    // R8: class none is ignored.
    grants_seen = 0;
    busy(4);
    cyc(1, 1, 1, 2'd0);
    quiet(50);
    chk("R8 class none grants", grants_seen, 0);

    // R7 and R8: each class; a second request while pending is ignored.
    for (int c = 1; c <= 3; c++) begin
      grants_seen = 0;
      busy(3);
      cyc(1, 1, 1, 2'(c));
      cyc(0, 0, 1, 2'(4 - c));
      quiet(45);
      chk("R7 one grant per request", grants_seen, 1);
    end

    // R7: a request during a long gap is granted at once.
    grants_seen = 0;
    cyc(0, 0, 1, 2'd2);
    quiet(3);
    chk("R7 late request grant", grants_seen, 1);

    // Random mix.
    for (int k = 0; k < 400; k++) begin
      int nb, nq;
      nb = $urandom_range(0, 4);
      nq = $urandom_range(0, 40);
      for (int i = 0; i < nb; i++)
        cyc($urandom_range(0, 1) == 1, 1'($urandom_range(0, 1)),
            $urandom_range(0, 3) == 0, 2'($urandom_range(0, 3)));
      for (int i = 0; i < nq; i++)
        cyc(0, 0, $urandom_range(0, 7) == 0, 2'($urandom_range(0, 3)));
    end

    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
    $finish;
  end

endmodule